// File: doc/BRIEF.md
# Serial Byte Transmitter with Fixed-Level Parity and Line Break

This block serialises one byte at a time onto an asynchronous serial line. A producer hands over a byte with a valid/ready handshake. The byte waits in a one-entry holding register until the shifter is free. The shifter then sends a frame: a low start bit, 5 to 8 data bits with the least significant bit first, an optional parity bit, and one or two high stop bits. Each bit lasts sixteen pulses of an external 16x rate enable. The enable comes from a baud generator outside this block.

Static format inputs set the frame shape. They choose the word length, the stop-bit count, whether parity is sent, and how the parity bit is formed. The parity bit can be odd or even parity over the data bits. It can also be a forced constant, called fixed-level parity. A separate break input pulls the serial line low while it is high. It does not touch the shifter, the bit timing or the handshake. An idle flag goes high once nothing is in flight. Software uses it to raise break only after the last frame has fully left.

Top module: `uart_tx_top`

## Requirements
- R1: After reset, txd_o is 1, idle_o is 1 and ready_o is 1.
- R2: A frame starts with a start bit of 0. The data bits follow, least significant first. Their count is set by wlen_i: 00 gives 5, 01 gives 6, 10 gives 7 and 11 gives 8. Every bit lasts exactly 16 cycles in which tick16_i is high.
- R3: stop2_i = 0 sends one stop bit of 1, and stop2_i = 1 sends two. The line stays at 1 after the frame.
- R4: With par_en_i = 0 no parity bit is sent, and par_sel_i and par_stick_i have no effect on the frame.
- R5: With par_en_i = 1 and par_stick_i = 0, one parity bit follows the data bits. par_sel_i = 0 makes the total count of ones over the data and parity bits odd. par_sel_i = 1 makes it even.
- R6: With par_en_i = 1 and par_stick_i = 1, the parity bit is a constant. It is 1 when par_sel_i = 0 and 0 when par_sel_i = 1.
- R7: While brk_i is 1, txd_o is 0, whether a frame is in flight or not. When brk_i returns to 0, the line level the shifter is producing shows on txd_o again at once.
- R8: brk_i does not change bit timing, frame content, ready_o or idle_o. Bits sent after break is released are the bits the frame would have had at those times.
- R9: ready_o is 1 while the holding register is empty. One byte can be accepted while a frame is in flight. idle_o is 1 only when no frame is in flight and no byte is held.
- R10: The shifter advances only in cycles with tick16_i high. With no tick, an ongoing frame holds its current bit indefinitely.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick16_i | input | 1 | 16x bit-rate enable pulse |
| wlen_i | input | 2 | Word length select (00=5 .. 11=8 bits) |
| stop2_i | input | 1 | 1 selects two stop bits |
| par_en_i | input | 1 | Parity bit enable |
| par_sel_i | input | 1 | Even parity / fixed level 0 when 1; odd parity / fixed level 1 when 0 |
| par_stick_i | input | 1 | Fixed-level parity select |
| brk_i | input | 1 | Break: forces txd_o low |
| data_i | input | 8 | Byte to send |
| valid_i | input | 1 | Byte offered |
| ready_o | output | 1 | Holding register can take a byte |
| txd_o | output | 1 | Serial output |
| idle_o | output | 1 | No frame in flight and no byte held |

## Verification
The assertions assume that tick16_i is a single-cycle enable and may arrive at any rate. They also assume that the format inputs do not change between the acceptance of a byte and the loading of its frame, since the format is captured at load. The stimulus changes the format only while idle_o is high. It drives break both while idle and in the middle of frames, releasing it before the stop bits. It also varies the tick rate and pauses the tick, so the timing checks count tick pulses and not clock cycles.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  localparam int unsigned DATA_W   = 8;
  localparam int unsigned MIN_BITS = 5;
  localparam int unsigned MAX_STOP = 2;
  localparam int unsigned FRAME_W  = 1 + DATA_W + 1 + MAX_STOP;
  localparam int unsigned BITS_W   = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic [1:0] wlen;
    logic       stop2;
    logic       par_en;
    logic       par_sel;
    logic       par_stick;
  } fmt_t;
endpackage

// File: rtl/uart_tx_hold.sv
module uart_tx_hold #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] data_i,
  input  logic         valid_i,
  output logic         ready_o,
  input  logic         take_i,
  output logic         full_o,
  output logic [W-1:0] q_o
);
  logic full_q;
  logic [W-1:0] q_q;

  assign ready_o = !full_q;
  assign full_o  = full_q;
  assign q_o     = q_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      full_q <= 1'b0;
      q_q    <= '0;
    end else if (valid_i && !full_q) begin
      full_q <= 1'b1;
      q_q    <= data_i;
    end else if (take_i) begin
      full_q <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_tx_framer.sv
module uart_tx_framer
  import uart_tx_pkg::*;
(
  input  logic [DATA_W-1:0]  data_i,
  input  fmt_t               fmt_i,
  output logic [FRAME_W-1:0] frame_o,
  output logic [BITS_W-1:0]  nbits_o
);
  logic [3:0]        nd;
  logic [DATA_W-1:0] dm;
  logic              par_bit;

  always_comb begin
    nd = 4'(MIN_BITS) + {2'b00, fmt_i.wlen};
    for (int i = 0; i < int'(DATA_W); i++) dm[i] = (i < int'(nd)) ? data_i[i] : 1'b0;
    // fixed level: sel=0 -> 1, sel=1 -> 0; else sel=1 even, sel=0 odd
    if (fmt_i.par_stick) par_bit = ~fmt_i.par_sel;
    else                 par_bit = fmt_i.par_sel ? ^dm : ~^dm;
    frame_o    = '1;                 // stop bits and unused tail stay 1
    frame_o[0] = 1'b0;
    for (int i = 0; i < int'(DATA_W); i++)
      if (i < int'(nd)) frame_o[1+i] = dm[i];
    if (fmt_i.par_en) frame_o[1+int'(nd)] = par_bit;
    nbits_o = BITS_W'(4'd2 + nd + {3'b000, fmt_i.par_en} + {3'b000, fmt_i.stop2});
  end
endmodule

// File: rtl/uart_tx_shifter.sv
module uart_tx_shifter #(
  parameter int unsigned FRAME_W = 12,
  parameter int unsigned BITS_W  = 4,
  parameter int unsigned OVS     = 16
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               load_i,
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [BITS_W-1:0]  nbits_i,
  output logic               busy_o,
  output logic [BITS_W-1:0]  left_o,
  output logic               line_o
);
  localparam int unsigned PH_W = $clog2(OVS);

  logic [FRAME_W-1:0] sh_q;
  logic [BITS_W-1:0]  left_q;
  logic [PH_W-1:0]    ph_q;
  logic               busy_q;

  assign busy_o = busy_q;
  assign left_o = left_q;
  assign line_o = busy_q ? sh_q[0] : 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q   <= '1;
      left_q <= '0;
      ph_q   <= '0;
      busy_q <= 1'b0;
    end else if (load_i) begin
      sh_q   <= frame_i;
      left_q <= nbits_i;
      ph_q   <= '0;
      busy_q <= 1'b1;
    end else if (busy_q && tick_i) begin
      if (ph_q == PH_W'(OVS - 1)) begin
        ph_q   <= '0;
        sh_q   <= {1'b1, sh_q[FRAME_W-1:1]};
        left_q <= left_q - 1'b1;
        if (left_q == BITS_W'(1)) busy_q <= 1'b0;
      end else begin
        ph_q <= ph_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/uart_tx_top.sv
module uart_tx_top
  import uart_tx_pkg::*;
#(
  parameter int unsigned OVS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick16_i,
  input  logic [1:0]        wlen_i,
  input  logic              stop2_i,
  input  logic              par_en_i,
  input  logic              par_sel_i,
  input  logic              par_stick_i,
  input  logic              brk_i,
  input  logic [DATA_W-1:0] data_i,
  input  logic              valid_i,
  output logic              ready_o,
  output logic              txd_o,
  output logic              idle_o
);
  fmt_t               fmt;
  logic               full, load, busy, line;
  logic [DATA_W-1:0]  held;
  logic [FRAME_W-1:0] frame;
  logic [BITS_W-1:0]  nbits, bits_left;

  assign fmt  = '{wlen: wlen_i, stop2: stop2_i, par_en: par_en_i,
                  par_sel: par_sel_i, par_stick: par_stick_i};
  assign load = full && !busy;

  uart_tx_hold #(.W(DATA_W)) hold_i (
    .clk_i, .rst_ni, .data_i, .valid_i, .ready_o,
    .take_i(load), .full_o(full), .q_o(held)
  );

  uart_tx_framer framer_i (
    .data_i(held), .fmt_i(fmt), .frame_o(frame), .nbits_o(nbits)
  );

  uart_tx_shifter #(.FRAME_W(FRAME_W), .BITS_W(BITS_W), .OVS(OVS)) shift_i (
    .clk_i, .rst_ni, .tick_i(tick16_i), .load_i(load), .frame_i(frame),
    .nbits_i(nbits), .busy_o(busy), .left_o(bits_left), .line_o(line)
  );

  // break gates only the pin; shifter runs on unaware
  assign txd_o  = line & ~brk_i;
  assign idle_o = !busy && !full;
endmodule

// File: rtl/uart_tx_chk.sv
module uart_tx_chk #(
  parameter int unsigned BITS_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick16_i,
  input logic              brk_i,
  input logic              valid_i,
  input logic              ready_o,
  input logic              txd_o,
  input logic              idle_o,
  input logic              busy,
  input logic [BITS_W-1:0] bits_left
);
  AST_BREAK_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_i |-> !txd_o);                                          // R7
  AST_IDLE_LINE_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_o && !brk_i) |-> txd_o);                              // R3
  AST_IDLE_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o |-> ready_o);                                        // R9
  AST_ACCEPT_NOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && ready_o) |=> !idle_o);                          // R9
  AST_NO_TICK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy && !tick16_i) |=> $stable(bits_left));                // R10
  AST_BUSY_NOT_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !idle_o);                                          // R9
endmodule

bind uart_tx_top uart_tx_chk #(.BITS_W(uart_tx_pkg::BITS_W)) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .tick16_i(tick16_i), .brk_i(brk_i),
  .valid_i(valid_i), .ready_o(ready_o), .txd_o(txd_o), .idle_o(idle_o),
  .busy(busy), .bits_left(bits_left)
);

// File: tb/uart_tx_top_tb_top.sv
module uart_tx_top_tb_top;
  logic clk_i = 1'b0, rst_ni = 1'b0, tick16_i = 1'b0;
  logic [1:0] wlen_i = 2'b11;
  logic stop2_i = 0, par_en_i = 0, par_sel_i = 0, par_stick_i = 0, brk_i = 0;
  logic [7:0] data_i = '0;
  logic valid_i = 0;
  logic ready_o, txd_o, idle_o;

  int n_chk = 0, n_err = 0, cyc = 0;
  int tick_div = 1, ph = 0;
  bit tick_run = 1;

  always #4 clk_i = ~clk_i;   // 125 MHz

  uart_tx_top dut_i (.*);

  always @(negedge clk_i) begin
    if (!tick_run) tick16_i <= 1'b0;
    else if (ph >= tick_div - 1) begin tick16_i <= 1'b1; ph <= 0; end
    else begin tick16_i <= 1'b0; ph <= ph + 1; end
  end

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wait_ticks(int n);
    int c = 0;
    while (c < n) begin
      @(posedge clk_i);
      if (tick16_i) c++;
    end
    @(negedge clk_i);
    #1;
  endtask

  task automatic set_fmt(int wl, int st2, int pm);
    wlen_i = 2'(wl); stop2_i = st2[0];
    case (pm)
      0: {par_en_i, par_sel_i, par_stick_i} = 3'b000;
      1: {par_en_i, par_sel_i, par_stick_i} = 3'b011;
      2: {par_en_i, par_sel_i, par_stick_i} = 3'b100;
      3: {par_en_i, par_sel_i, par_stick_i} = 3'b110;
      4: {par_en_i, par_sel_i, par_stick_i} = 3'b101;
      default: {par_en_i, par_sel_i, par_stick_i} = 3'b111;
    endcase
  endtask

  task automatic push(logic [7:0] d);
    data_i = d; valid_i = 1'b1;
    while (!ready_o) @(negedge clk_i);
    @(negedge clk_i);
    valid_i = 1'b0;
  endtask

  // expected bits from the requirements; brk_bit < 0 means no break
  task automatic check_frame(logic [7:0] d, int brk_bit, bit idle_end);
    int nd = 5 + int'(wlen_i);
    int n = 0;
    int ones = 0;
    logic eb [12];
    string tg [12];
    int t = 0;
    eb[n] = 1'b0; tg[n] = "R2"; n++;
    for (int i = 0; i < nd; i++) begin
      eb[n] = d[i]; tg[n] = "R2"; n++; ones += int'(d[i]);
    end
    if (par_en_i) begin
      if (par_stick_i) begin eb[n] = !par_sel_i; tg[n] = "R6"; end
      else begin eb[n] = par_sel_i ? ones[0] : !ones[0]; tg[n] = "R5"; end
      n++;
    end
    for (int i = 0; i <= int'(stop2_i); i++) begin eb[n] = 1'b1; tg[n] = "R3"; n++; end
    @(negedge clk_i);
    while (txd_o !== 1'b0 && t < 5000) begin @(negedge clk_i); t++; end
    chk("R2 start seen", txd_o, 0);
    wait_ticks(8);
    for (int k = 0; k < n; k++) begin
      if (k > 0) wait_ticks(16);
      if (k == brk_bit) begin brk_i = 1'b1; #1; chk("R7 break mid-frame", txd_o, 0); end
      else begin
        if (k == brk_bit + 1) begin brk_i = 1'b0; #1; end
        chk((k == brk_bit + 1) ? "R8 after break" : tg[k], txd_o, eb[k]);
      end
      chk("R9 busy not idle", idle_o, 0);
    end
    wait_ticks(8);
    chk(par_en_i ? "R3 frame end" : "R4 frame length", idle_o, idle_end);
    if (idle_end) chk("R3 line high after", txd_o, 1);
  endtask

  initial begin
    logic [7:0] pats [3];
    pats[0] = 8'h00; pats[1] = 8'hB7; pats[2] = 8'h5A;
    #1;
    chk("R1 txd in reset", txd_o, 1);
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk("R1 txd", txd_o, 1);
    chk("R1 idle", idle_o, 1);
    chk("R1 ready", ready_o, 1);

    // sweep all formats and parity modes
    for (int wl = 0; wl < 4; wl++)
      for (int st = 0; st < 2; st++)
        for (int pm = 0; pm < 6; pm++)
          for (int p = 0; p < 3; p++) begin
            set_fmt(wl, st, pm);
            push(pats[p]);
            check_frame(pats[p], -1, 1'b1);
          end

    // break while idle
    brk_i = 1'b1;
    repeat (5) @(negedge clk_i); #1;
    chk("R7 idle break", txd_o, 0);
    chk("R8 idle unchanged", idle_o, 1);
    chk("R8 ready unchanged", ready_o, 1);
    brk_i = 1'b0; #1;
    chk("R7 release", txd_o, 1);

    // break in mid-frame, timing and content intact
    set_fmt(3, 1, 3); push(8'hC3); check_frame(8'hC3, 2, 1'b1);
    set_fmt(1, 0, 4); push(8'h2D); check_frame(8'h2D, 5, 1'b1);

    // one byte held behind an active frame
    set_fmt(3, 0, 0);
    push(8'h5A);
    push(8'hA1);
    #1;
    chk("R9 holding full", ready_o, 0);
    chk("R9 not idle", idle_o, 0);
    check_frame(8'h5A, -1, 1'b0);
    check_frame(8'hA1, -1, 1'b1);

    // slow tick rate
    tick_div = 3;
    set_fmt(2, 1, 5); push(8'h6E); check_frame(8'h6E, -1, 1'b1);
    set_fmt(0, 0, 2); push(8'h13); check_frame(8'h13, -1, 1'b1);
    tick_div = 1;

    // paused tick holds the start bit
    tick_run = 0;
    set_fmt(3, 0, 3);
    push(8'h96);
    repeat (60) @(negedge clk_i); #1;
    chk("R10 start held", txd_o, 0);
    chk("R10 not idle", idle_o, 0);
    tick_run = 1;
    check_frame(8'h96, -1, 1'b1);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule